// File: doc/BRIEF.md
# Eight-output addressable latch and 1-of-8 demultiplexer

This block holds eight single-bit storage cells behind one shared data input and a 3-bit address. Two active-low controls, a write enable and a clear, pick one of four modes on every rising clock edge:
- **Write mode** updates the one addressed cell.
- **Hold mode** freezes all cells.
- **Route mode** steers the data bit to the addressed output while driving all other outputs low.
- **Clear mode** zeroes every output and every cell.

Inputs are sampled on the rising edge. The eight outputs are registered, so they show the result of the most recent edge.

In route mode the outputs bypass the stored cells, and the cells keep their contents. A later hold edge shows those contents again.

An address monitor raises a one-cycle flag when the address moves by two or more bits between consecutive samples while the enable is low. This is the situation in which a level-sensitive latch of this kind could briefly write an unintended cell. Integrators use the flag to check that wide address changes are made only in hold mode.

Top module: `addr_bit_latch`

## Requirements
- R1: While `rst` is high at a rising edge, all outputs and `multi_flip` are 0 after that edge, and all stored cells are 0.
- R2: Write mode (`en_n`=0, `clr_n`=1): at the edge, the cell selected by `addr` takes `din`, and the other seven cells keep their values. After the edge, `q` equals the updated cells.
- R3: Hold mode (`en_n`=1, `clr_n`=1): all cells keep their values, and `q` shows them after the edge, whatever `addr` and `din` are.
- R4: Route mode (`en_n`=0, `clr_n`=0): after the edge, the addressed bit of `q` equals `din` and every other bit of `q` is 0.
- R5: Clear mode (`en_n`=1, `clr_n`=0): after the edge, `q` is all zeros whatever `addr` and `din` are, and every stored cell is cleared to 0.
- R6: `addr` is straight binary with `addr[0]` least significant. Address value k selects cell k and output `q[k]`, so 3'b000 selects `q[0]` and 3'b111 selects `q[7]`.
- R7: Route mode leaves the stored cells unchanged. The first hold edge afterwards shows the contents held before route mode.
- R8: `multi_flip` is 1 for the cycle after an edge if and only if, at that edge:
  - `en_n` was 0;
  - the address differs in two or more bits from the address sampled at the previous edge;
  - that previous edge was not in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Cell / output select, binary |
| din | input | 1 | Data bit |
| en_n | input | 1 | Active-low enable (write or route) |
| clr_n | input | 1 | Active-low clear (route or clear) |
| q | output | 8 | Registered outputs |
| multi_flip | output | 1 | One-cycle flag: wide address change while enabled |

## Verification
A stored cell that was corrupted stays invisible through route and clear edges. It shows on `q` at the first write or hold edge afterwards, one cycle after that edge. This is why the bench keeps a behavioural copy of all eight cells and compares `q` on every cycle, including directed route-then-hold sequences. A wrong or missing reset of the previous-address register shows as a spurious or missing `multi_flip` in the first cycle after an enabled edge. A wrong bit order shows as the wrong `q` bit rising one cycle after a single-address write.

// File: rtl/latch_pkg.sv
package latch_pkg;

    typedef enum logic [1:0] {
        MODE_WRITE = 2'd0,
        MODE_HOLD  = 2'd1,
        MODE_ROUTE = 2'd2,
        MODE_CLEAR = 2'd3
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  data;
    } cmd_t;

    function automatic mode_e mode_of(input logic en_n, input logic clr_n);
        case ({en_n, clr_n})
            2'b01:   return MODE_WRITE;
            2'b11:   return MODE_HOLD;
            2'b00:   return MODE_ROUTE;
            default: return MODE_CLEAR;
        endcase
    endfunction

    function automatic int unsigned bit_diff(input logic [31:0] a, input logic [31:0] b);
        int unsigned n;
        logic [31:0] x;
        x = a ^ b;
        n = 0;
        for (int i = 0; i < 32; i++) n += int'(x[i]);
        return n;
    endfunction

endpackage

// File: rtl/latch_addr_dec.sv
module latch_addr_dec #(
    parameter int ADDR_W = 3,
    localparam int NOUT = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NOUT-1:0]   sel
);
    for (genvar i = 0; i < NOUT; i++) begin : g_sel
        assign sel[i] = (addr == ADDR_W'(i));
    end
endmodule

// File: rtl/latch_bit_bank.sv
module latch_bit_bank
    import latch_pkg::*;
#(
    parameter int NOUT = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  cmd_t            cmd,
    input  logic [NOUT-1:0] sel,
    output logic [NOUT-1:0] cell_d,
    output logic [NOUT-1:0] cell_q
);
    for (genvar i = 0; i < NOUT; i++) begin : g_cell
        always_comb begin
            case (cmd.mode)
                MODE_WRITE: cell_d[i] = sel[i] ? cmd.data : cell_q[i];
                MODE_CLEAR: cell_d[i] = 1'b0;
                default:    cell_d[i] = cell_q[i];
            endcase
        end

        always_ff @(posedge clk) begin
            if (rst) cell_q[i] <= 1'b0;
            else     cell_q[i] <= cell_d[i];
        end
    end

    // R2
    write_others_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.mode == MODE_WRITE) |=> (((cell_q ^ $past(cell_q)) & ~$past(sel)) == '0));
    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.mode == MODE_HOLD) |=> $stable(cell_q));
    // R7
    route_keeps_cells_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.mode == MODE_ROUTE) |=> $stable(cell_q));
    // R5
    clear_cells_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.mode == MODE_CLEAR) |=> (cell_q == '0));
endmodule

// File: rtl/latch_out_sel.sv
module latch_out_sel
    import latch_pkg::*;
#(
    parameter int NOUT = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  cmd_t            cmd,
    input  logic [NOUT-1:0] sel,
    input  logic [NOUT-1:0] cell_d,
    output logic [NOUT-1:0] q
);
    logic [NOUT-1:0] q_d;

    always_comb begin
        case (cmd.mode)
            MODE_ROUTE: q_d = sel & {NOUT{cmd.data}};
            MODE_CLEAR: q_d = '0;
            default:    q_d = cell_d;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_d;
    end

    // R4
    route_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.mode == MODE_ROUTE) |=> $onehot0(q));
    // R4
    route_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.mode == MODE_ROUTE && !cmd.data) |=> (q == '0));
    // R5
    clear_out_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.mode == MODE_CLEAR) |=> (q == '0));
endmodule

// File: rtl/latch_addr_mon.sv
module latch_addr_mon
    import latch_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              flag
);
    logic [ADDR_W-1:0] last_addr;
    logic              last_ok;
    logic              wide;

    assign wide = bit_diff(32'(addr), 32'(last_addr)) > 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_addr <= '0;
            last_ok   <= 1'b0;
            flag      <= 1'b0;
        end else begin
            last_addr <= addr;
            last_ok   <= 1'b1;
            flag      <= !en_n && last_ok && wide;
        end
    end

    // R8
    flag_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        flag |-> $past(!en_n));
endmodule

// File: rtl/addr_bit_latch.sv
module addr_bit_latch
    import latch_pkg::*;
#(
    parameter int ADDR_W = 3,
    localparam int NOUT = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    input  logic              en_n,
    input  logic              clr_n,
    output logic [NOUT-1:0]   q,
    output logic              multi_flip
);
    cmd_t            cmd;
    logic [NOUT-1:0] sel;
    logic [NOUT-1:0] cell_d;
    logic [NOUT-1:0] cell_q;

    assign cmd.mode = mode_of(en_n, clr_n);
    assign cmd.data = din;

    latch_addr_dec #(.ADDR_W(ADDR_W)) dec_i (
        .addr (addr),
        .sel  (sel)
    );

    latch_bit_bank #(.NOUT(NOUT)) bank_i (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .sel    (sel),
        .cell_d (cell_d),
        .cell_q (cell_q)
    );

    latch_out_sel #(.NOUT(NOUT)) outs_i (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .sel    (sel),
        .cell_d (cell_d),
        .q      (q)
    );

    latch_addr_mon #(.ADDR_W(ADDR_W)) mon_i (
        .clk  (clk),
        .rst  (rst),
        .en_n (en_n),
        .addr (addr),
        .flag (multi_flip)
    );

    // R1
    reset_out_chk: assert property (@(posedge clk)
        rst |=> (q == '0 && !multi_flip && cell_q == '0));
    // R3
    hold_out_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.mode == MODE_HOLD) |=> (q == cell_q));
endmodule

// File: tb/addr_bit_latch_tb.sv
module addr_bit_latch_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = '0;
    logic       din = 1'b0;
    logic       en_n = 1'b1;
    logic       clr_n = 1'b1;
    logic [7:0] q;
    logic       multi_flip;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    bit [7:0] m_cells = '0;
    bit [7:0] m_q = '0;
    bit       m_flag = 0;
    bit [2:0] m_last = '0;
    bit       m_last_ok = 0;

    always #5ns clk = ~clk;

    addr_bit_latch dut_i (
        .clk(clk), .rst(rst), .addr(addr), .din(din),
        .en_n(en_n), .clr_n(clr_n), .q(q), .multi_flip(multi_flip)
    );

    function automatic int popc(bit [2:0] v);
        return int'(v[0]) + int'(v[1]) + int'(v[2]);
    endfunction

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s q act %h exp %h", tag, act, exp);
        end
    endtask

    task automatic check1(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s multi_flip act %b exp %b", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic step(bit e, bit c, bit [2:0] a, bit d);
        string tag;
        en_n = e; clr_n = c; addr = a; din = d;
        @(posedge clk);
        case ({e, c})
            2'b01: begin m_cells[a] = d; m_q = m_cells; tag = "R2"; end
            2'b11: begin m_q = m_cells; tag = "R3"; end
            2'b00: begin m_q = 8'(d) << a; tag = "R4"; end
            default: begin m_cells = '0; m_q = '0; tag = "R5"; end
        endcase
        m_flag = !e && m_last_ok && (popc(a ^ m_last) >= 2);
        m_last = a;
        m_last_ok = 1;
        @(negedge clk);
        check8(tag, q, m_q);
        check1("R8", multi_flip, m_flag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check8("R1", q, 8'h00);
        check1("R1", multi_flip, 1'b0);
        rst = 1'b0;

        // R6: each address writes its own output bit, binary with addr[0] LSB
        for (int k = 0; k < 8; k++) step(1, 0, 3'(k), 0);   // clear first
        for (int k = 0; k < 8; k++) begin
            step(1, 0, 3'd0, 0);
            step(0, 1, 3'(k), 1);
            check8("R6", q, 8'h01 << k);
        end

        // R2: build a pattern, keep others
        step(1, 1, 3'd0, 0);
        step(0, 1, 3'd1, 1);
        step(0, 1, 3'd3, 1);
        step(0, 1, 3'd7, 1);
        check8("R2", q, 8'h8a);
        // R3: hold ignores addr/din
        step(1, 1, 3'd5, 1);
        check8("R3", q, 8'h8a);

        // R7: route, then hold restores cells
        step(1, 1, 3'd4, 0);
        step(0, 0, 3'd4, 1);
        check8("R4", q, 8'h10);
        step(1, 1, 3'd4, 0);
        check8("R7", q, 8'h8a);

        // R5: clear wipes cells too
        step(1, 0, 3'd6, 1);
        check8("R5", q, 8'h00);
        step(1, 1, 3'd6, 1);
        check8("R5", q, 8'h00);

        // R8: one-bit change no flag, two-bit flag, while disabled no flag
        step(1, 1, 3'd0, 0);
        step(0, 1, 3'd1, 0);
        check1("R8", multi_flip, 1'b0);
        step(0, 1, 3'd6, 0);
        check1("R8", multi_flip, 1'b1);
        step(1, 1, 3'd1, 0);
        check1("R8", multi_flip, 1'b0);
        step(0, 0, 3'd6, 0);
        check1("R8", multi_flip, 1'b1);

        // random mix of all modes
        for (int n = 0; n < 4000; n++) begin
            bit [31:0] r;
            r = $urandom;
            step(r[0], r[1], r[4:2], r[5]);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule